// File: doc/BRIEF.md
# Software-Loaded Fully Associative Translation Buffer

This block holds a small set of address translations that software installs by hand. An install is a two-step operation. The first command names a virtual page and carries the physical page number. This step reserves a slot for the page, but the slot is not yet usable. The second command, sent to the same address, carries the protection word and turns the entry on.

A combinational lookup port compares a virtual address against every slot. It returns the physical page and the decoded protection fields of the matching entry, or a miss. A separate purge port removes one page by address or empties the whole buffer. Checking the protection fields against an access is left to the logic downstream.

A slot is chosen for an address install in one of two ways. If some slot already covers the page, the first covering slot is reused, and any live covering entries are switched off. If no slot covers the page, a round-robin pointer picks a victim slot and then moves on by one.

Top module: `soft_tlb`

## Requirements
- R1: After reset every slot is empty. A lookup of any address, including 0xFFFFFFFF, misses.
- R2: An address install (`cmd_op`=0) stores the page `cmd_vaddr[31:12]` with the range page*4096 to page*4096+4095. It takes the physical page number from `cmd_data[24:5]`. The entry stays switched off, so a lookup in that page misses.
- R3: A protection install (`cmd_op`=1) decodes `cmd_data` into fields: access id [18:1], user [19], level A [21:20], level B [23:22], kind [26:24], break [27], dirty [28], trap [29]. It then switches the entry on. A lookup returns these fields.
- R4: A lookup hits for every address from the first to the last byte of an installed page. It misses one byte below and one byte above the page. On a hit, `lk_ppn` is the stored physical page number.
- R5: If several slots match, the lowest-indexed matching slot is the one reported. The hit flag is that slot's on/off state.
- R6: When no slot covers the page, an address install replaces the slot under the round-robin pointer. The pointer starts at 0, steps by one after each such install, and wraps from 15 to 0.
- R7: When a live slot already covers the page, an address install switches that slot off and rewrites it in place. The round-robin pointer does not move.
- R8: A protection install whose address matches no slot changes nothing. It raises `prot_err` for the single cycle after the clock edge that takes the command.
- R9: A purge by address (`purge_all`=0) empties only the live slot holding that page. Purging an unmapped address changes nothing.
- R10: A purge with `purge_all`=1 empties every slot.
- R11: When `purge_valid` and `cmd_valid` are both high in one cycle, only the purge takes effect and the command is dropped.
- R12: On a miss, `lk_ppn` and every protection field output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Install command present |
| cmd_op | input | 1 | 0 = address install, 1 = protection install |
| cmd_vaddr | input | 32 | Virtual address of the install |
| cmd_data | input | 32 | Physical page word or protection word |
| purge_valid | input | 1 | Purge request present |
| purge_all | input | 1 | 1 = empty all slots, 0 = purge one page |
| purge_vaddr | input | 32 | Address of the page to purge |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a switched-on entry |
| lk_ppn | output | 20 | Physical page number |
| lk_acc_id | output | 18 | Access identifier |
| lk_user | output | 1 | User flag |
| lk_priv_a | output | 2 | Privilege level A |
| lk_priv_b | output | 2 | Privilege level B |
| lk_kind | output | 3 | Access kind code |
| lk_brk | output | 1 | Break flag |
| lk_dirty | output | 1 | Dirty flag |
| lk_trap | output | 1 | Trap-on-reference flag |
| prot_err | output | 1 | Protection install found no slot |

## Verification
The assertions assume that the lookup address stays put across an install or purge whenever they relate the lookup result to that operation. They also assume that a purge or command is treated as taken in the cycle its valid is high. The stimulus meets this by driving every input just after a rising edge and by keeping the lookup address separate from the cycles that carry commands. Expected results come from page numbers and words that the bench chooses. The bench tracks the slot order by hand so that round-robin eviction and in-place reuse can be observed through lookups alone.

// File: rtl/soft_tlb_pkg.sv
// Shared widths, field positions and the entry record for the soft TLB.
// Assumes a 32-bit virtual address and a 4 KiB page.
package soft_tlb_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_BITS = 12;
    parameter int PPN_W     = 20;
    parameter int DATA_W    = 32;
    parameter int PPN_LSB   = 5;
    parameter int ACC_W     = 18;
    parameter int ACC_LSB   = 1;
    parameter int USER_BIT  = 19;
    parameter int PRA_LSB   = 20;
    parameter int PRB_LSB   = 22;
    parameter int KIND_LSB  = 24;
    parameter int BRK_BIT   = 27;
    parameter int DIRTY_BIT = 28;
    parameter int TRAP_BIT  = 29;
    parameter int VPN_W     = VA_W - PAGE_BITS;

    typedef struct packed {
        logic [VA_W-1:0]  va_lo;
        logic [VA_W-1:0]  va_hi;
        logic [PPN_W-1:0] ppn;
        logic [ACC_W-1:0] acc_id;
        logic             user;
        logic [1:0]       priv_a;
        logic [1:0]       priv_b;
        logic [2:0]       kind;
        logic             brk;
        logic             dirty;
        logic             trap;
        logic             live;
    } tlb_entry_t;

    // Empty slot: zero fields, range start all ones so nothing can match.
    function automatic tlb_entry_t empty_entry();
        tlb_entry_t e;
        e       = '0;
        e.va_lo = '1;
        return e;
    endfunction
endpackage

// File: rtl/tlb_range_match.sv
// Compares one address against every slot's inclusive range.
// Assumes ranges are already stored; purely combinational.
module tlb_range_match
    import soft_tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t        ents [N],
    input  logic [VA_W-1:0]   addr,
    output logic [N-1:0]      hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Range test for slot g.
        assign hits[g] = (ents[g].va_lo <= addr) && (addr <= ents[g].va_hi);
    end
endmodule

// File: rtl/tlb_first_sel.sv
// Finds the lowest set bit of a vector and reports its index.
// Assumes nothing about how many bits are set.
module tlb_first_sel #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_rr_ptr.sv
// Round-robin victim pointer that steps by one and wraps at N-1.
// Assumes advance is a single-cycle request.
module tlb_rr_ptr #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    // Hold, step or wrap the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/soft_tlb.sv
// Software-loaded fully associative TLB. Two-step install, combinational
// lookup, purge of one page or all. Purge outranks a same-cycle command.
// Assumes page-aligned ranges of one page per slot.
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [VA_W-1:0]   cmd_vaddr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              purge_valid,
    input  logic              purge_all,
    input  logic [VA_W-1:0]   purge_vaddr,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ACC_W-1:0]  lk_acc_id,
    output logic              lk_user,
    output logic [1:0]        lk_priv_a,
    output logic [1:0]        lk_priv_b,
    output logic [2:0]        lk_kind,
    output logic              lk_brk,
    output logic              lk_dirty,
    output logic              lk_trap,
    output logic              prot_err
);
    tlb_entry_t       tbl     [N];
    tlb_entry_t       tbl_nxt [N];
    logic [N-1:0]     lk_match, mt_match;
    logic             lk_found, mt_found;
    logic [IDX_W-1:0] lk_idx, mt_idx, rr_ptr;
    logic             rr_adv, err_nxt;
    logic [VA_W-1:0]  mt_addr;
    tlb_entry_t       sel;
    logic             unused_bits;

    assign unused_bits = ^{cmd_data[DATA_W-1:TRAP_BIT+1], cmd_data[0]};

    // Maintenance address: purge outranks command.
    assign mt_addr = purge_valid ? purge_vaddr : cmd_vaddr;

    tlb_range_match #(.N(N)) u_lk_cmp (.ents(tbl), .addr(lk_vaddr), .hits(lk_match));
    tlb_range_match #(.N(N)) u_mt_cmp (.ents(tbl), .addr(mt_addr),  .hits(mt_match));
    tlb_first_sel #(.N(N), .IDX_W(IDX_W)) u_lk_sel (.vec(lk_match), .found(lk_found), .idx(lk_idx));
    tlb_first_sel #(.N(N), .IDX_W(IDX_W)) u_mt_sel (.vec(mt_match), .found(mt_found), .idx(mt_idx));
    tlb_rr_ptr #(.N(N), .IDX_W(IDX_W)) u_rr (.clk(clk), .rst_n(rst_n), .advance(rr_adv), .ptr(rr_ptr));

    // Lookup result: lowest matching slot, reported only when live.
    always_comb begin
        sel    = lk_found ? tbl[lk_idx] : empty_entry();
        lk_hit = lk_found && sel.live;
        if (!lk_hit) sel = '0;
        lk_ppn    = sel.ppn;
        lk_acc_id = sel.acc_id;
        lk_user   = sel.user;
        lk_priv_a = sel.priv_a;
        lk_priv_b = sel.priv_b;
        lk_kind   = sel.kind;
        lk_brk    = sel.brk;
        lk_dirty  = sel.dirty;
        lk_trap   = sel.trap;
    end

    // Next table state from purge or install.
    always_comb begin
        tlb_entry_t       ne;
        logic [IDX_W-1:0] dest;
        for (int i = 0; i < N; i++) tbl_nxt[i] = tbl[i];
        rr_adv  = 1'b0;
        err_nxt = 1'b0;
        ne      = empty_entry();
        dest    = '0;
        if (purge_valid) begin
            if (purge_all) begin
                for (int i = 0; i < N; i++) tbl_nxt[i] = empty_entry();
            end else if (mt_found && tbl[mt_idx].live) begin
                tbl_nxt[mt_idx] = empty_entry();
            end
        end else if (cmd_valid && !cmd_op) begin
            for (int i = 0; i < N; i++)
                if (mt_match[i] && tbl[i].live) tbl_nxt[i] = empty_entry();
            dest     = mt_found ? mt_idx : rr_ptr;
            rr_adv   = !mt_found;
            ne.va_lo = {cmd_vaddr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
            ne.va_hi = {cmd_vaddr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b1}}};
            ne.ppn   = cmd_data[PPN_LSB +: PPN_W];
            tbl_nxt[dest] = ne;
        end else if (cmd_valid && cmd_op) begin
            if (mt_found) begin
                ne        = tbl[mt_idx];
                ne.acc_id = cmd_data[ACC_LSB +: ACC_W];
                ne.user   = cmd_data[USER_BIT];
                ne.priv_a = cmd_data[PRA_LSB +: 2];
                ne.priv_b = cmd_data[PRB_LSB +: 2];
                ne.kind   = cmd_data[KIND_LSB +: 3];
                ne.brk    = cmd_data[BRK_BIT];
                ne.dirty  = cmd_data[DIRTY_BIT];
                ne.trap   = cmd_data[TRAP_BIT];
                ne.live   = 1'b1;
                tbl_nxt[mt_idx] = ne;
            end else begin
                err_nxt = 1'b1;
            end
        end
    end

    // Table and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tbl[i] <= empty_entry();
            prot_err <= 1'b0;
        end else begin
            for (int i = 0; i < N; i++) tbl[i] <= tbl_nxt[i];
            prot_err <= err_nxt;
        end
    end
endmodule

// File: rtl/soft_tlb_checker.sv
// Temporal checks on the soft TLB ports, bound into every instance.
// Assumes lookup address stability where a rule relates it to an operation.
module soft_tlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_op,
    input logic [31:0] cmd_vaddr,
    input logic        purge_valid,
    input logic        purge_all,
    input logic [31:0] purge_vaddr,
    input logic [31:0] lk_vaddr,
    input logic        lk_hit,
    input logic [19:0] lk_ppn,
    input logic [17:0] lk_acc_id,
    input logic [2:0]  lk_kind,
    input logic        prot_err
);
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> $past(cmd_valid && cmd_op && !purge_valid));

    assert_purge_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_valid && purge_all) |=> !lk_hit);

    assert_purge_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_valid && !purge_all && lk_vaddr == purge_vaddr) |=> (!$stable(lk_vaddr) || !lk_hit));

    assert_addr_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_op && !purge_valid && lk_vaddr == cmd_vaddr) |=> (!$stable(lk_vaddr) || !lk_hit));

    assert_miss_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && lk_acc_id == '0 && lk_kind == '0));
endmodule

bind soft_tlb soft_tlb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vaddr(cmd_vaddr), .purge_valid(purge_valid), .purge_all(purge_all),
    .purge_vaddr(purge_vaddr), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_ppn(lk_ppn), .lk_acc_id(lk_acc_id), .lk_kind(lk_kind), .prot_err(prot_err)
);

// File: tb/tb_soft_tlb.sv
// Scoreboard bench: driver tasks queue expected lookups, a monitor compares.
module tb_soft_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [31:0] cmd_vaddr = '0, cmd_data = '0;
    logic        purge_valid = 1'b0, purge_all = 1'b0;
    logic [31:0] purge_vaddr = '0, lk_vaddr = '0;
    logic        lk_hit, lk_user, lk_brk, lk_dirty, lk_trap, prot_err;
    logic [19:0] lk_ppn;
    logic [17:0] lk_acc_id;
    logic [1:0]  lk_priv_a, lk_priv_b;
    logic [2:0]  lk_kind;
    int total = 0, bad = 0, cycles = 0;

    typedef struct {
        logic        hit;
        logic [19:0] ppn;
        logic [28:0] prot;
        string       tag;
    } exp_t;
    exp_t q[$];

    soft_tlb dut (.*);

    always #4 clk = ~clk;

    // Protection fields as positioned in R3.
    function automatic logic [28:0] prot_of(logic [31:0] w);
        return {w[18:1], w[19], w[21:20], w[23:22], w[26:24], w[27], w[28], w[29]};
    endfunction

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [28:0] got;
            e   = q.pop_front();
            got = {lk_acc_id, lk_user, lk_priv_a, lk_priv_b, lk_kind, lk_brk, lk_dirty, lk_trap};
            total++;
            if (lk_hit !== e.hit || lk_ppn !== e.ppn || got !== e.prot) begin
                bad++;
                $display("FAIL %s: hit=%0b ppn=%h prot=%h expected hit=%0b ppn=%h prot=%h",
                         e.tag, lk_hit, lk_ppn, got, e.hit, e.ppn, e.prot);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic look(input logic [31:0] va, input logic hit, input logic [19:0] ppn,
                        input logic [31:0] w, input string tag);
        exp_t e;
        lk_vaddr = va;
        e.hit  = hit;
        e.ppn  = hit ? ppn : 20'h0;
        e.prot = hit ? prot_of(w) : 29'h0;
        e.tag  = tag;
        q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic cmd(input logic op, input logic [31:0] va, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_vaddr = va; cmd_data = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic purge(input logic all, input logic [31:0] va);
        purge_valid = 1'b1; purge_all = all; purge_vaddr = va;
        @(posedge clk); #1;
        purge_valid = 1'b0;
    endtask

    task automatic check_err(input logic exp, input string tag);
        total++;
        if (prot_err !== exp) begin
            bad++;
            $display("FAIL %s: prot_err=%0b expected %0b", tag, prot_err, exp);
        end
    endtask

    task automatic install(input int page, input logic [19:0] ppn, input logic [31:0] w);
        cmd(1'b0, page << 12, {7'h0, ppn, 5'h0});
        cmd(1'b1, page << 12, w);
    endtask

    localparam logic [31:0] W1 = (32'h2A5A5 << 1) | (32'd1 << 19) | (32'd2 << 20) | (32'd1 << 22)
                               | (32'd5 << 24) | (32'd1 << 28) | (32'd1 << 29);
    localparam logic [31:0] W2 = (32'h00123 << 1) | (32'd3 << 24) | (32'd1 << 27) | (32'd3 << 22);

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        look(32'h0000_1234, 0, 0, 0, "R1 empty after reset");
        look(32'hFFFF_FFFF, 0, 0, 0, "R1 all-ones address misses");
        // R2 address install leaves entry off; junk bits outside [24:5]
        cmd(1'b0, 32'h0001_2345, 32'hE000_001F | (32'hABCDE << 5));
        look(32'h0001_2345, 0, 0, 0, "R2 entry off after address install");
        // R3 protection install
        cmd(1'b1, 32'h0001_2800, W1);
        check_err(1'b0, "R8 no error on matched protection install");
        look(32'h0001_2345, 1, 20'hABCDE, W1, "R3 fields decoded");
        // R4 range edges
        look(32'h0001_2000, 1, 20'hABCDE, W1, "R4 first byte");
        look(32'h0001_2FFF, 1, 20'hABCDE, W1, "R4 last byte");
        look(32'h0001_3000, 0, 0, 0, "R4 R12 byte above misses");
        look(32'h0001_1FFF, 0, 0, 0, "R4 R12 byte below misses");
        // R8 orphan protection install
        cmd(1'b1, 32'h0000_5000, W2);
        check_err(1'b1, "R8 error pulse");
        look(32'h0000_5000, 0, 0, 0, "R8 orphan install ignored");
        check_err(1'b0, "R8 pulse lasts one cycle");
        look(32'h0001_2000, 1, 20'hABCDE, W1, "R8 existing entry unchanged");
        // R10 purge all (pointer now 1)
        purge(1'b1, 0);
        look(32'h0001_2000, 0, 0, 0, "R10 purge all");
        // R6 fill 16 pages: page 0x100+k lands in slot (k+1)%16
        for (int k = 0; k < 16; k++) install(32'h100 + k, 20'h500 + 20'(k), W2);
        for (int k = 0; k < 16; k++) look((32'h100 + k) << 12, 1, 20'h500 + 20'(k), W2, "R6 R5 full table hits");
        install(32'h200, 20'h600, W1);
        look(32'h0010_0000, 0, 0, 0, "R6 victim under pointer evicted");
        look(32'h0010_F000, 1, 20'h50F, W2, "R6 wrapped slot kept");
        look(32'h0020_0000, 1, 20'h600, W1, "R6 new page hits");
        // R7 in-place reinstall of page 0x105
        cmd(1'b0, 32'h0010_5000, 32'h777 << 5);
        look(32'h0010_5000, 0, 0, 0, "R7 covering entry switched off");
        cmd(1'b1, 32'h0010_5000, W1);
        look(32'h0010_5000, 1, 20'h777, W1, "R7 slot rewritten");
        install(32'h201, 20'h601, W2);
        look(32'h0010_1000, 0, 0, 0, "R7 pointer unmoved, next victim");
        look(32'h0010_2000, 1, 20'h502, W2, "R7 following slot kept");
        // R9 purge by page
        purge(1'b0, 32'h0010_3ABC);
        look(32'h0010_3000, 0, 0, 0, "R9 page purged");
        look(32'h0010_4000, 1, 20'h504, W2, "R9 neighbour kept");
        purge(1'b0, 32'h0030_0000);
        look(32'h0010_4000, 1, 20'h504, W2, "R9 unmapped purge no effect");
        // R11 purge beats command
        purge_valid = 1'b1; purge_all = 1'b0; purge_vaddr = 32'h0010_4000;
        cmd(1'b0, 32'h0040_0000, 32'h888 << 5);
        purge_valid = 1'b0;
        look(32'h0010_4000, 0, 0, 0, "R11 purge applied");
        cmd(1'b1, 32'h0040_0000, W1);
        check_err(1'b1, "R11 dropped install left no slot");
        look(32'h0040_0000, 0, 0, 0, "R11 command dropped");
        // R10 final purge all
        purge(1'b1, 0);
        look(32'h0010_F000, 0, 0, 0, "R10 purge all slot 0");
        look(32'h0020_0000, 0, 0, 0, "R10 purge all slot 1");
        @(posedge clk); #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule